// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm Match

The block keeps time in whole seconds for a processor that reaches it over a 32-bit APB-style register bus. An external one-cycle pulse, `tick_i`, advances a 32-bit seconds counter. Software can preset this counter. It can also program a 32-bit alarm value. When the counter steps onto that value, a sticky interrupt flag is set, and `irq_o` follows that flag as a level.

A second, relative view of time is available as well. Writing its offset records the present seconds value as a base. Reading it returns how many seconds have passed since then. Two read-only identification words sit near the top of a 4 KiB window.

Every access must be a full 32-bit word. Any access that is malformed or not allowed is refused with a one-cycle error response and changes no state. The bus always completes in a single access cycle. Read data and the error response are valid during the access phase, and register writes take effect at the clock edge that ends it.

Top module: `sec_rtc`

## Requirements
- R1: After reset the seconds counter, alarm value, relative base and interrupt flag are all zero, and `irq_o` is low.
- R2: A read of offset 0x000 returns the seconds counter. The counter increases by one, modulo 2^32, on each cycle where `tick_i` is high, unless a preset write happens in that same cycle.
- R3: A write to offset 0x000 is refused with `pslverr_o` and changes nothing.
- R4: A write to offset 0x00C presets the seconds counter to the written data from the next cycle on, and this takes priority over a tick in the same cycle. A read of 0x00C is refused with `pslverr_o` and returns zero.
- R5: Offset 0x004 holds the alarm value, and it reads back what was last written.
- R6: When a tick moves the seconds counter to a value equal to the alarm value, the interrupt flag is set. The flag stays set until software clears it, and `irq_o` equals the flag.
- R7: A write of zero to offset 0x008 clears the interrupt flag, and a write of any non-zero value sets it. A read of 0x008 returns the flag in bit 0, with bits 31:1 zero.
- R8: A write to offset 0x010, whatever its data, stores the current seconds value as the base. A read of 0x010 returns the seconds counter minus the base, modulo 2^32.
- R9: A read of 0xFE0 returns 0x00041030, and a read of 0xFD8 returns 0x000FFFFF. A write to either offset is refused with `pslverr_o`.
- R10: An access whose `psize_i` is not 2'b10 (4 bytes) is refused with `pslverr_o` and changes nothing. The other codes are 2'b00 for 1 byte, 2'b01 for 2 bytes and 2'b11 reserved.
- R11: An access to any offset not listed above, unaligned offsets included, is refused with `pslverr_o` and changes nothing. `pslverr_o` is high only in an access phase, that is, when `psel_i` and `penable_i` are both high.
- R12: If a write to offset 0x008 lands in the same cycle as an alarm match, the written value decides the flag.
- R13: `prdata_o` is zero in every cycle that is not an accepted read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| psel_i | input | 1 | Select |
| penable_i | input | 1 | Access phase enable |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte offset within the 4 KiB window |
| psize_i | input | 2 | Access size code (2'b10 = 4 bytes) |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| pready_o | output | 1 | Ready, always high |
| pslverr_o | output | 1 | Error response for a refused access |
| irq_o | output | 1 | Level interrupt, equal to the flag |

## Verification
The bench targets the corner cases below.

- **Counter wrap.** It presets the counter to 0xFFFFFFFF and ticks it. A design that saturates or ignores the carry would not read back zero.
- **Relative counter wrap.** It checks the relative counter when the counter has wrapped behind its base. A design that subtracted in the wrong order would return the negated count.
- **Same-cycle collisions.** It lines a tick up with a preset, and an alarm match up with a write to the flag. A design with the wrong priority would count one second too many, or leave `irq_o` in the wrong state.
- **Refused accesses.** It issues accesses of the wrong size, writes to read-only offsets and reads of the preset offset. A design that let any of these through would show a changed register on the next read.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] OFS_SEC   = 12'h000;
  localparam logic [AW-1:0] OFS_ALARM = 12'h004;
  localparam logic [AW-1:0] OFS_FLAG  = 12'h008;
  localparam logic [AW-1:0] OFS_LOAD  = 12'h00C;
  localparam logic [AW-1:0] OFS_REL   = 12'h010;
  localparam logic [AW-1:0] OFS_MASK  = 12'hFD8;
  localparam logic [AW-1:0] OFS_IDENT = 12'hFE0;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [2:0] {
    RD_NONE, RD_SEC, RD_ALARM, RD_FLAG, RD_REL, RD_IDENT, RD_MASK
  } rd_sel_e;

  typedef struct packed {
    logic alarm;
    logic flag;
    logic load;
    logic rel;
  } wr_strb_t;
endpackage

// File: rtl/sec_rtc_decode.sv
module sec_rtc_decode
  import sec_rtc_pkg::*;
(
  input  logic          acc_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output logic          err_o,
  output rd_sel_e       rd_sel_o,
  output wr_strb_t      wr_o
);
  logic legal;

  always_comb begin
    legal    = 1'b0;
    rd_sel_o = RD_NONE;
    wr_o     = '0;
    unique case (addr_i)
      OFS_SEC:   begin legal = !write_i; rd_sel_o = RD_SEC; end
      OFS_ALARM: begin legal = 1'b1; rd_sel_o = RD_ALARM; wr_o.alarm = write_i; end
      OFS_FLAG:  begin legal = 1'b1; rd_sel_o = RD_FLAG;  wr_o.flag  = write_i; end
      OFS_LOAD:  begin legal = write_i; wr_o.load = write_i; end
      OFS_REL:   begin legal = 1'b1; rd_sel_o = RD_REL;   wr_o.rel   = write_i; end
      OFS_IDENT: begin legal = !write_i; rd_sel_o = RD_IDENT; end
      OFS_MASK:  begin legal = !write_i; rd_sel_o = RD_MASK; end
      default:   legal = 1'b0;
    endcase
    if (size_i != SIZE_WORD) legal = 1'b0;
    err_o = acc_i && !legal;
    if (!acc_i || !legal) begin
      rd_sel_o = RD_NONE;
      wr_o     = '0;
    end
    if (write_i) rd_sel_o = RD_NONE;
  end
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_we_i,
  input  logic             rel_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] sec_o,
  output logic [WIDTH-1:0] rel_o,
  output logic             step_o,
  output logic [WIDTH-1:0] sec_nxt_o
);
  logic [WIDTH-1:0] sec_q, base_q;

  assign step_o    = tick_i && !load_we_i;  // preset beats the tick
  assign sec_nxt_o = sec_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      base_q <= '0;
    end else begin
      if (load_we_i)   sec_q <= wdata_i;
      else if (tick_i) sec_q <= sec_nxt_o;
      if (rel_we_i)    base_q <= sec_q;
    end
  end

  assign sec_o = sec_q;
  assign rel_o = sec_q - base_q;
endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alarm_we_i,
  input  logic             flag_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] sec_nxt_i,
  output logic [WIDTH-1:0] alarm_o,
  output logic             flag_o
);
  logic [WIDTH-1:0] alarm_q;
  logic             flag_q;
  logic             hit;

  assign hit = step_i && (sec_nxt_i == alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (alarm_we_i) alarm_q <= wdata_i;
      if (flag_we_i)  flag_q  <= |wdata_i;  // software write wins over a match
      else if (hit)   flag_q  <= 1'b1;
    end
  end

  assign alarm_o = alarm_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter logic [DW-1:0] IDENT_WORD = 32'h0004_1030,
  parameter logic [DW-1:0] MASK_WORD  = 32'h000F_FFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [1:0]    psize_i,
  input  logic [DW-1:0] pwdata_i,
  output logic [DW-1:0] prdata_o,
  output logic          pready_o,
  output logic          pslverr_o,
  output logic          irq_o
);
  logic          acc;
  rd_sel_e       rd_sel;
  wr_strb_t      wr;
  logic [DW-1:0] sec_w, rel_w, sec_nxt_w, alarm_w;
  logic          step_w, flag_w;

  assign acc = psel_i && penable_i;

  sec_rtc_decode i_decode (
    .acc_i    (acc),
    .write_i  (pwrite_i),
    .addr_i   (paddr_i),
    .size_i   (psize_i),
    .err_o    (pslverr_o),
    .rd_sel_o (rd_sel),
    .wr_o     (wr)
  );

  sec_rtc_counter #(.WIDTH(DW)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_we_i (wr.load),
    .rel_we_i  (wr.rel),
    .wdata_i   (pwdata_i),
    .sec_o     (sec_w),
    .rel_o     (rel_w),
    .step_o    (step_w),
    .sec_nxt_o (sec_nxt_w)
  );

  sec_rtc_alarm #(.WIDTH(DW)) i_alarm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alarm_we_i (wr.alarm),
    .flag_we_i  (wr.flag),
    .wdata_i    (pwdata_i),
    .step_i     (step_w),
    .sec_nxt_i  (sec_nxt_w),
    .alarm_o    (alarm_w),
    .flag_o     (flag_w)
  );

  always_comb begin
    unique case (rd_sel)
      RD_SEC:   prdata_o = sec_w;
      RD_ALARM: prdata_o = alarm_w;
      RD_FLAG:  prdata_o = {{(DW-1){1'b0}}, flag_w};
      RD_REL:   prdata_o = rel_w;
      RD_IDENT: prdata_o = IDENT_WORD;
      RD_MASK:  prdata_o = MASK_WORD;
      default:  prdata_o = '0;
    endcase
  end

  assign pready_o = 1'b1;
  assign irq_o    = flag_w;
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        psel_i,
  input logic        penable_i,
  input logic        pwrite_i,
  input logic [11:0] paddr_i,
  input logic [1:0]  psize_i,
  input logic [31:0] pwdata_i,
  input logic        pslverr_o,
  input logic        irq_o,
  input logic [31:0] sec_i
);
  logic acc, wr_ok_flag;
  assign acc        = psel_i && penable_i;
  assign wr_ok_flag = acc && pwrite_i && paddr_i == 12'h008 && psize_i == 2'b10;

  a_r10_bad_size_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && psize_i != 2'b10 |-> pslverr_o);
  a_r11_err_only_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> psel_i && penable_i);
  a_r3_data_write_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && pwrite_i && paddr_i == 12'h000 |-> pslverr_o);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_flag && pwdata_i == 32'd0 |=> !irq_o);
  a_r7_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_flag && pwdata_i != 32'd0 |=> irq_o);
  a_r2_sec_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !(acc && pwrite_i && paddr_i == 12'h00C) |=> $stable(sec_i));
  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i) || $past(wr_ok_flag));
endmodule

bind sec_rtc sec_rtc_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .psize_i   (psize_i),
  .pwdata_i  (pwdata_i),
  .pslverr_o (pslverr_o),
  .irq_o     (irq_o),
  .sec_i     (sec_w)
);

// File: tb/test_sec_rtc.sv
module test_sec_rtc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        psel_i = 1'b0;
  logic        penable_i = 1'b0;
  logic        pwrite_i = 1'b0;
  logic [11:0] paddr_i = '0;
  logic [1:0]  psize_i = 2'b10;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        pready_o, pslverr_o, irq_o;

  int unsigned n_chk = 0, n_err = 0;
  logic [31:0] m_sec = 0, m_alarm = 0, m_base = 0;
  logic        m_flag = 1'b0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  sec_rtc i_sec_rtc (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(bit wr, logic [11:0] a, logic [1:0] sz);
    if (sz != 2'b10) return 1'b1;
    case (a)
      12'h000, 12'hFE0, 12'hFD8: return wr;
      12'h004, 12'h008, 12'h010: return 1'b0;
      12'h00C: return !wr;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    case (a)
      12'h000: return m_sec;
      12'h004: return m_alarm;
      12'h008: return {31'd0, m_flag};
      12'h010: return m_sec - m_base;
      12'hFE0: return 32'h0004_1030;
      12'hFD8: return 32'h000F_FFFF;
      default: return 32'd0;
    endcase
  endfunction

  // one clock cycle: drive at negedge, check before posedge, update model
  task automatic cyc(bit tk, bit sel, bit en, bit wr, logic [11:0] a, logic [1:0] sz, logic [31:0] d);
    bit acc, err, ld;
    logic [31:0] nsec;
    tick_i = tk; psel_i = sel; penable_i = en; pwrite_i = wr;
    paddr_i = a; psize_i = sz; pwdata_i = d;
    #1;
    acc = sel && en;
    err = acc && exp_err(wr, a, sz);
    chk(err ? "R10/R11 err" : "R11 no err", {31'd0, pslverr_o}, {31'd0, err});
    if (acc && !wr && !err) chk("R2/R5/R7/R8/R9 read", prdata_o, exp_rd(a));
    else chk("R13 idle rdata", prdata_o, 32'd0);
    @(posedge clk_i);
    ld = acc && wr && !err && a == 12'h00C;
    nsec = m_sec;
    if (ld) nsec = d;
    else if (tk) begin
      nsec = m_sec + 1;
      if (nsec == m_alarm) m_flag = 1'b1;  // R6
    end
    if (acc && wr && !err) begin
      case (a)
        12'h004: m_alarm = d;
        12'h008: m_flag = (d != 0);  // R12: write wins
        12'h010: m_base = m_sec;
        default: ;
      endcase
    end
    m_sec = nsec;
    @(negedge clk_i);
    chk("R6 irq level", {31'd0, irq_o}, {31'd0, m_flag});
  endtask

  task automatic xfer(bit wr, logic [11:0] a, logic [1:0] sz, logic [31:0] d, bit tk = 0);
    cyc(1'b0, 1'b1, 1'b0, wr, a, sz, d);
    cyc(tk, 1'b1, 1'b1, wr, a, sz, d);
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [0:8];
    void'($urandom(32'd1234));
    addrs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'hFE0, 12'hFD8, 12'h014, 12'h002};
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    xfer(0, 12'h000, 2'b10, 0);
    xfer(0, 12'h004, 2'b10, 0);
    xfer(0, 12'h008, 2'b10, 0);
    xfer(0, 12'h010, 2'b10, 0);
    // R2 ticks
    repeat (5) cyc(1, 0, 0, 0, 0, 2'b10, 0);
    xfer(0, 12'h000, 2'b10, 0);
    // R3, R4 read, R9 writes refused
    xfer(1, 12'h000, 2'b10, 32'h55);
    xfer(0, 12'h00C, 2'b10, 0);
    xfer(1, 12'hFE0, 2'b10, 1);
    xfer(0, 12'h000, 2'b10, 0);
    // R4 wrap and preset over tick
    xfer(1, 12'h00C, 2'b10, 32'hFFFF_FFFF, 1'b1);
    xfer(0, 12'h000, 2'b10, 0);
    cyc(1, 0, 0, 0, 0, 2'b10, 0);
    xfer(0, 12'h000, 2'b10, 0);
    // R8 relative wrap
    xfer(1, 12'h00C, 2'b10, 32'hFFFF_FFFE);
    xfer(1, 12'h010, 2'b10, 32'hDEAD);
    repeat (4) cyc(1, 0, 0, 0, 0, 2'b10, 0);
    xfer(0, 12'h010, 2'b10, 0);
    // R6 alarm then R7 clear/force
    xfer(1, 12'h004, 2'b10, m_sec + 2);
    repeat (3) cyc(1, 0, 0, 0, 0, 2'b10, 0);
    xfer(0, 12'h008, 2'b10, 0);
    xfer(1, 12'h008, 2'b10, 0);
    xfer(1, 12'h008, 2'b10, 32'h8000_0000);
    xfer(1, 12'h008, 2'b10, 0);
    // R12 collision: match with clear write
    xfer(1, 12'h004, 2'b10, m_sec + 1);
    xfer(1, 12'h008, 2'b10, 0, 1'b1);
    // R10 bad sizes
    xfer(1, 12'h004, 2'b00, 32'h1);
    xfer(1, 12'h008, 2'b01, 32'h1);
    xfer(0, 12'h004, 2'b11, 0);
    xfer(0, 12'h004, 2'b10, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit tk = ($urandom % 4) == 0;
      if ($urandom % 3 == 0) cyc(tk, 0, 0, 0, 0, 2'b10, 0);
      else begin
        logic [11:0] a = addrs[$urandom % 9];
        logic [1:0]  sz = ($urandom % 6 == 0) ? 2'($urandom) : 2'b10;
        logic [31:0] d = ($urandom % 2) ? m_sec + ($urandom % 4) : ($urandom % 3 == 0 ? 32'd0 : $urandom);
        xfer($urandom % 2, a, sz, d, tk);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule